// File: doc/BRIEF.md
# Stack-Based Expression Evaluator

This block is a zero-operand arithmetic unit. It evaluates expressions written in reverse Polish order. A command stream arrives on a valid/ready interface. Each command either pushes a signed constant, discards the top entry, or combines the two topmost entries with add, subtract, multiply or divide. Arithmetic commands carry no operand field. They consume the two topmost entries and leave one result in their place.

The two topmost entries are held in dedicated registers. All deeper entries are kept in a small internal register array. A push moves the second register into the array, and a pop or an arithmetic command refills the second register from the array. The data movement and the command both complete in the single cycle in which the command is accepted, so the evaluator takes one command every clock.

The block reports the following on its outputs:
- the current top value;
- a signed stack pointer, which is -1 when the stack is empty;
- empty and full levels;
- sticky flags for underflow, overflow and division by zero. These flags hold until reset.

Top module: `stk_eval`

## Requirements
- R1: After reset the stack pointer reads -1, `empty` is 1, `full` is 0, `tos` is 0, and `underflow`, `overflow` and `div_zero` are all 0.
- R2: `cmd_ready` is always 1. A push (op code 0) accepted while not full raises the stack pointer by one and shows the pushed value on `tos` in the cycle after acceptance.
- R3: A pop (op code 1) with at least one entry lowers the stack pointer by one. The entry that was second from the top becomes the new top.
- R4: Add (op code 2) leaves second + top. Subtract (op code 3) leaves second minus top: pushing 10 and then 20 and subtracting gives -10. Each binary operation lowers the stack pointer by one net.
- R5: Multiply (op code 4) leaves the low DATA_W bits of the signed product. With 16-bit data, 300 x 300 gives 24464.
- R6: Divide (op code 5) leaves second / top, truncated toward zero. -7 / 2 gives -3 and 7 / -2 gives -3.
- R7: A divide with a top of zero pushes 0, still consumes both operands, and sets the sticky `div_zero` flag.
- R8: A binary operation with fewer than two entries, or a pop on an empty stack, sets the sticky `underflow` flag. The stack is left unchanged.
- R9: With MEM_DEPTH+2 entries, `full` is 1. A further push sets the sticky `overflow` flag and is dropped: the stack pointer and `tos` do not change.
- R10: Entries deeper than the second are preserved through spill and refill. This holds when commands are accepted on back-to-back cycles.
- R11: The command sequence push 5, push 3, push 7, multiply, add, push 8, subtract leaves 18 as the only entry, with stack pointer 0.
- R12: Op codes 6 and 7, and any cycle with `cmd_valid` low, change neither the stack nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_op | input | 3 | 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div |
| cmd_data | input | DATA_W | Signed constant for push |
| tos | output | DATA_W | Top-of-stack value (0 when empty) |
| sp | output | clog2(MEM_DEPTH+3)+1 | Signed stack pointer, -1 when empty |
| empty | output | 1 | No entries |
| full | output | 1 | MEM_DEPTH+2 entries |
| underflow | output | 1 | Sticky: operation lacked operands |
| overflow | output | 1 | Sticky: push dropped while full |
| div_zero | output | 1 | Sticky: division by zero seen |

## Verification
The hardest case to reach is the deepest one. In that case the backing array is completely occupied, and values must then come back out of every array slot through refill in the right order. The stimulus fills the whole stack with distinct values on consecutive cycles. It then attempts one extra push to hit the overflow boundary. Next it pops several times, checking that each refilled value surfaces in order. Finally it folds the remaining entries together with back-to-back adds, so that a refill error would change the final sum.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
   typedef enum logic [2:0] {
      OP_PUSH = 3'd0,
      OP_POP  = 3'd1,
      OP_ADD  = 3'd2,
      OP_SUB  = 3'd3,
      OP_MUL  = 3'd4,
      OP_DIV  = 3'd5
   } stk_op_e;
endpackage

// File: rtl/stk_alu.sv
`timescale 1ns/1ps
module stk_alu #(
   parameter int DATA_W = 16
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] nos_val,
   input  logic [DATA_W-1:0] top_val,
   output logic [DATA_W-1:0] result,
   output logic              zero_div
);
   import stk_pkg::*;

   logic signed [DATA_W-1:0] a_s, b_s;
   logic signed [DATA_W-1:0] quot;
   logic        [DATA_W-1:0] prod;

   assign a_s = $signed(nos_val);
   assign b_s = $signed(top_val);
   assign prod = nos_val * top_val;

   // divide: truncate toward zero; -1 handled explicitly to define wrap
   always_comb begin
      zero_div = 1'b0;
      quot     = '0;
      if (b_s == '0) begin
         zero_div = 1'b1;
      end else if (b_s == -1) begin
         quot = -a_s;
      end else begin
         quot = a_s / b_s;
      end
   end

   always_comb begin
      case (op)
         OP_ADD:  result = nos_val + top_val;
         OP_SUB:  result = nos_val - top_val;
         OP_MUL:  result = prod;
         OP_DIV:  result = quot;
         default: result = '0;
      endcase
   end
endmodule

// File: rtl/stk_spill_mem.sv
`timescale 1ns/1ps
module stk_spill_mem #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 6,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == AW'(g))) begin
            slot[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_addr == AW'(i)) rd_data = slot[i];
      end
   end
endmodule

// File: rtl/stk_eval.sv
`timescale 1ns/1ps
module stk_eval #(
   parameter int DATA_W    = 16,
   parameter int MEM_DEPTH = 6,
   localparam int CAP      = MEM_DEPTH + 2,
   localparam int CNT_W    = $clog2(CAP + 1),
   localparam int SP_W     = CNT_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic [2:0]             cmd_op,
   input  logic [DATA_W-1:0]      cmd_data,
   output logic [DATA_W-1:0]      tos,
   output logic signed [SP_W-1:0] sp,
   output logic                   empty,
   output logic                   full,
   output logic                   underflow,
   output logic                   overflow,
   output logic                   div_zero
);
   import stk_pkg::*;

   localparam int AW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;
   localparam logic [CNT_W-1:0] CAP_C   = CNT_W'(CAP);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO_C   = CNT_W'(2);
   localparam logic [CNT_W-1:0] THREE_C = CNT_W'(3);

   if (DATA_W < 2) begin : g_bad_w
      $error("stk_eval: DATA_W must be at least 2");
   end
   if (MEM_DEPTH < 2) begin : g_bad_d
      $error("stk_eval: MEM_DEPTH must be at least 2");
   end

   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] top_r, nos_r;
   logic              udf_r, ovf_r, dz_r;

   logic [DATA_W-1:0] alu_res, fill_val;
   logic              alu_dz;
   logic [CNT_W-1:0]  wr_idx, rd_idx;
   logic              spill_en, is_bin, has_deep;

   assign wr_idx   = count - TWO_C;
   assign rd_idx   = count - THREE_C;
   assign has_deep = (count >= THREE_C);
   assign is_bin   = (cmd_op == OP_ADD) || (cmd_op == OP_SUB) ||
                     (cmd_op == OP_MUL) || (cmd_op == OP_DIV);
   assign spill_en = cmd_valid && (cmd_op == OP_PUSH) &&
                     (count >= TWO_C) && (count != CAP_C);

   stk_alu #(.DATA_W(DATA_W)) u_alu (
      .op      (cmd_op),
      .nos_val (nos_r),
      .top_val (top_r),
      .result  (alu_res),
      .zero_div(alu_dz)
   );

   stk_spill_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
      .clk    (clk),
      .wr_en  (spill_en),
      .wr_addr(wr_idx[AW-1:0]),
      .wr_data(nos_r),
      .rd_addr(rd_idx[AW-1:0]),
      .rd_data(fill_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         top_r <= '0;
         nos_r <= '0;
         udf_r <= 1'b0;
         ovf_r <= 1'b0;
         dz_r  <= 1'b0;
      end else if (cmd_valid) begin
         if (cmd_op == OP_PUSH) begin
            if (count == CAP_C) begin
               ovf_r <= 1'b1;
            end else begin
               top_r <= cmd_data;
               nos_r <= top_r;
               count <= count + ONE_C;
            end
         end else if (cmd_op == OP_POP) begin
            if (count == '0) begin
               udf_r <= 1'b1;
            end else begin
               top_r <= nos_r;
               if (has_deep) nos_r <= fill_val;
               count <= count - ONE_C;
            end
         end else if (is_bin) begin
            if (count < TWO_C) begin
               udf_r <= 1'b1;
            end else begin
               top_r <= alu_res;
               if (has_deep) nos_r <= fill_val;
               count <= count - ONE_C;
               if ((cmd_op == OP_DIV) && alu_dz) dz_r <= 1'b1;
            end
         end
      end
   end

   assign cmd_ready = 1'b1;
   assign tos       = (count == '0) ? '0 : top_r;
   assign sp        = $signed(SP_W'({1'b0, count})) - $signed(SP_W'(1));
   assign empty     = (count == '0);
   assign full      = (count == CAP_C);
   assign underflow = udf_r;
   assign overflow  = ovf_r;
   assign div_zero  = dz_r;
endmodule

// File: rtl/stk_eval_chk.sv
`timescale 1ns/1ps
module stk_eval_chk #(
   parameter int DATA_W    = 16,
   parameter int MEM_DEPTH = 6,
   localparam int CAP      = MEM_DEPTH + 2,
   localparam int CNT_W    = $clog2(CAP + 1),
   localparam int SP_W     = CNT_W + 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_valid,
   input logic                   cmd_ready,
   input logic [2:0]             cmd_op,
   input logic [DATA_W-1:0]      cmd_data,
   input logic [DATA_W-1:0]      tos,
   input logic signed [SP_W-1:0] sp,
   input logic                   empty,
   input logic                   full,
   input logic                   underflow,
   input logic                   overflow,
   input logic                   div_zero
);
   import stk_pkg::*;

   logic bin_cmd;
   assign bin_cmd = cmd_valid && (cmd_op >= 3'd2) && (cmd_op <= 3'd5);

   // R2
   ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready);

   // R2
   push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_PUSH && !full) |=>
      (sp == $past(sp) + 1 && tos == $past(cmd_data)));

   // R9
   full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_PUSH && full) |=>
      ($stable(sp) && $stable(tos) && overflow));

   // R8
   short_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_cmd && sp < 1) |=> ($stable(sp) && underflow));

   // R8
   udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);

   // R4
   bin_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_cmd && sp >= 1) |=> (sp == $past(sp) - 1));

   // R7
   div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_DIV && sp >= 1 && tos == '0) |=>
      (div_zero && tos == '0));

   // R1
   empty_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (sp == -1));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid) |=> ($stable(sp) && $stable(tos)));
endmodule

bind stk_eval stk_eval_chk #(.DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_op(cmd_op), .cmd_data(cmd_data), .tos(tos), .sp(sp), .empty(empty),
   .full(full), .underflow(underflow), .overflow(overflow), .div_zero(div_zero)
);

// File: tb/stk_eval_bench.sv
`timescale 1ns/1ps
module stk_eval_bench;
   localparam int DW   = 16;
   localparam int MD   = 6;
   localparam int CAP  = MD + 2;
   localparam int SPW  = $clog2(CAP + 1) + 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmd_valid = 1'b0;
   logic           cmd_ready;
   logic [2:0]     cmd_op = 3'd0;
   logic [DW-1:0]  cmd_data = '0;
   logic [DW-1:0]  tos;
   logic signed [SPW-1:0] sp;
   logic           empty, full, underflow, overflow, div_zero;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   stk_eval #(.DATA_W(DW), .MEM_DEPTH(MD)) u_stk_eval (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .tos(tos), .sp(sp),
      .empty(empty), .full(full), .underflow(underflow),
      .overflow(overflow), .div_zero(div_zero)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int top_i();
      return int'($signed(tos));
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cmd_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cmd(input logic [2:0] op, input int val);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_data  = DW'(val);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 sp", int'(sp), -1);
      check("R1 empty", int'(empty), 1);
      check("R1 full", int'(full), 0);
      check("R1 tos", top_i(), 0);
      check("R1 flags", int'({underflow, overflow, div_zero}), 0);
      check("R2 ready", int'(cmd_ready), 1);
   endtask

   task automatic t_addsub();
      do_reset();
      cmd(3'd0, 10);
      cmd(3'd0, 20);
      check("R2 push tos", top_i(), 20);
      check("R2 push sp", int'(sp), 1);
      cmd(3'd3, 0);
      check("R4 sub", top_i(), -10);
      check("R4 sub sp", int'(sp), 0);
      cmd(3'd0, 7);
      cmd(3'd2, 0);
      check("R4 add", top_i(), -3);
      cmd(3'd0, 11);
      cmd(3'd1, 0);
      check("R3 pop tos", top_i(), -3);
      check("R3 pop sp", int'(sp), 0);
   endtask

   task automatic t_mul();
      do_reset();
      cmd(3'd0, 300);
      cmd(3'd0, 300);
      cmd(3'd4, 0);
      check("R5 mul wrap", top_i(), 24464);
      cmd(3'd0, -4);
      cmd(3'd0, 5);
      cmd(3'd4, 0);
      check("R5 mul neg", top_i(), -20);
      check("R5 sp", int'(sp), 1);
   endtask

   task automatic t_div();
      do_reset();
      cmd(3'd0, -7);
      cmd(3'd0, 2);
      cmd(3'd5, 0);
      check("R6 div neg dividend", top_i(), -3);
      cmd(3'd0, 7);
      cmd(3'd0, -2);
      cmd(3'd5, 0);
      check("R6 div neg divisor", top_i(), -3);
      check("R6 no dz", int'(div_zero), 0);
      do_reset();
      cmd(3'd0, 9);
      cmd(3'd0, 0);
      cmd(3'd5, 0);
      check("R7 dz result", top_i(), 0);
      check("R7 dz sp", int'(sp), 0);
      check("R7 dz flag", int'(div_zero), 1);
   endtask

   task automatic t_underflow();
      do_reset();
      cmd(3'd2, 0);
      check("R8 add empty flag", int'(underflow), 1);
      check("R8 add empty sp", int'(sp), -1);
      do_reset();
      cmd(3'd0, 4);
      cmd(3'd3, 0);
      check("R8 one entry flag", int'(underflow), 1);
      check("R8 one entry sp", int'(sp), 0);
      check("R8 one entry tos", top_i(), 4);
      do_reset();
      cmd(3'd1, 0);
      check("R8 pop empty flag", int'(underflow), 1);
      check("R8 pop empty sp", int'(sp), -1);
   endtask

   task automatic t_full_spill();
      do_reset();
      for (int i = 1; i <= CAP; i++) begin
         @(negedge clk);
         cmd_valid = 1'b1;
         cmd_op    = 3'd0;
         cmd_data  = DW'(i * 3);
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R9 full", int'(full), 1);
      check("R9 sp at cap", int'(sp), CAP - 1);
      cmd(3'd0, 99);
      check("R9 overflow", int'(overflow), 1);
      check("R9 sp held", int'(sp), CAP - 1);
      check("R9 tos held", top_i(), CAP * 3);
      for (int k = 1; k <= 3; k++) begin
         cmd(3'd1, 0);
         check("R10 refill pop", top_i(), (CAP - k) * 3);
      end
      for (int k = 0; k < CAP - 4; k++) begin
         @(negedge clk);
         cmd_valid = 1'b1;
         cmd_op    = 3'd2;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R10 burst sum", top_i(), 3 * (CAP - 3) * (CAP - 2) / 2);
      check("R10 burst sp", int'(sp), 0);
   endtask

   task automatic t_expr();
      do_reset();
      cmd(3'd0, 5);
      cmd(3'd0, 3);
      cmd(3'd0, 7);
      cmd(3'd4, 0);
      cmd(3'd2, 0);
      cmd(3'd0, 8);
      cmd(3'd3, 0);
      check("R11 result", top_i(), 18);
      check("R11 sp", int'(sp), 0);
   endtask

   task automatic t_ignore();
      do_reset();
      cmd(3'd0, 42);
      cmd(3'd6, 0);
      cmd(3'd7, 0);
      check("R12 tos", top_i(), 42);
      check("R12 sp", int'(sp), 0);
      @(negedge clk);
      cmd_op = 3'd1;
      cmd_valid = 1'b0;
      @(negedge clk);
      check("R12 idle sp", int'(sp), 0);
      check("R12 flags", int'({underflow, overflow, div_zero}), 0);
   endtask

   initial begin
      t_reset();
      t_addsub();
      t_mul();
      t_div();
      t_underflow();
      t_full_spill();
      t_expr();
      t_ignore();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule